// File: doc/BRIEF.md
# Stereo Serial Audio Transmit Port

This block turns a pair of 24-bit two's complement audio words, one for the left channel and one for the right, into a serial bit stream on a single data line. Each word goes out MSB first in a 32-slot half-frame. The bit clock and the frame (word-select) clock come from one of two places. An internal divider can generate them from the system clock, and the block then drives them out (master). Or a remote device supplies them, and the block samples them into its own clock domain (slave).

Two framings are supported. In left-justified framing the MSB occupies the first bit period after a frame-clock edge. In I2S framing it arrives one bit period later. There is no control register for the choice. The block reads the level that board strapping puts on the data pin, once, on the first system clock after reset is released. It then takes over the pin. New sample pairs are written into a holding register by a valid strobe. The pair moves into the shifter only at the start of a left channel, so the two words of a frame always belong together.

Top module: `sap_tx_port`

## Requirements
- R1: While `rst_n` is low, `sdo_oe_o` is 0 and `sdo_o` is 0.
- R2: On the first rising `clk` after `rst_n` goes high, `sdo_strap_i` is latched as the framing: 1 selects I2S, 0 selects left-justified. Later changes of `sdo_strap_i` have no effect until the next reset. `sdo_oe_o` rises at that same edge and stays high.
- R3: In master mode `sdo_o` changes only on the `clk` edge that follows a falling edge of `sclk_o`. It holds its value for the whole time `sclk_o` is high.
- R4: Left-justified: the left word is sent while the frame clock is high. The word's MSB is in slot 0, the first bit period after a frame-clock edge. The 24 bits follow MSB first in slots 0 to 23, and slots 24 to 31 carry 0.
- R5: I2S: the left word is sent while the frame clock is low. Slot 0 carries 0, the MSB is in slot 1, the LSB is in slot 24, and slots 25 to 31 carry 0.
- R6: Master mode (`slave_mode` = 0): `clk_drive_o` = 1. `sclk_o` has a period of 2*HALF_DIV clocks (4 by default). `lrck_o` changes only together with a falling `sclk_o`, and holds each level for 32 `sclk_o` periods, giving 64 per frame.
- R7: Slave mode (`slave_mode` = 1): `clk_drive_o` = 0 and `sclk_o` and `lrck_o` are held at 0. Bits are shifted on falling edges of `ext_sclk_i`, and the slot count restarts at every edge of `ext_lrck_i`.
- R8: A pulse of `sample_valid_i` stores both words in a holding register. Both words move to the shifter together at the start of a left channel. A pair written during a frame appears only in later frames, and when several pairs are written before a frame start, the last one is sent.
- R9: After reset the data line carries 0 until the first frame-clock transition has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (master) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | 1: use external bit/frame clocks; 0: generate them |
| ext_sclk_i | input | 1 | External bit clock (slave mode) |
| ext_lrck_i | input | 1 | External frame clock (slave mode) |
| sample_l_i | input | 24 | Left channel word, two's complement |
| sample_r_i | input | 24 | Right channel word, two's complement |
| sample_valid_i | input | 1 | Store the presented pair in the holding register |
| sdo_strap_i | input | 1 | Level sensed on the data pin, framing strap |
| sdo_o | output | 1 | Serial data |
| sdo_oe_o | output | 1 | Output enable of the data pin |
| sclk_o | output | 1 | Generated bit clock (master mode) |
| lrck_o | output | 1 | Generated frame clock (master mode) |
| clk_drive_o | output | 1 | Output enable of the clock pins |

## Verification
Each framing is run in both clock modes with a set of word pairs. Near-extreme words whose lowest bit differs from their neighbours (0x800001 against 0x7FFFFE) expose a stream shifted by one slot, as well as a truncated or reversed word. All-ones against all-zeros and one-bit words expose a left/right swap, and show whether the delayed-MSB framing leaves slot 0 empty. Further runs change the pair in the middle of a left half and write two pairs back to back, which separates correct frame-start latching from latching at any time. A run with a frozen external frame clock confirms that the line stays quiet until framing is established.

// File: rtl/sap_pkg.sv
package sap_pkg;

    // Framing selected by the strap level on the data pin
    typedef enum logic {
        FMT_LJ  = 1'b0,
        FMT_I2S = 1'b1
    } sap_fmt_e;

    // One bit-clock event as seen in the system clock domain
    typedef struct packed {
        logic fall;   // single-cycle pulse: bit clock just fell
        logic lrck;   // frame clock level after that fall
    } sap_evt_t;

endpackage

// File: rtl/sap_bclk_gen.sv
module sap_bclk_gen #(
    parameter int HALF_DIV = 2,
    parameter int SLOTS    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    output logic              sclk_o,
    output logic              lrck_o,
    output sap_pkg::sap_evt_t evt_o
);
    localparam int PH_N  = 2 * HALF_DIV;
    localparam int PH_W  = (PH_N > 1) ? $clog2(PH_N) : 1;
    localparam int BIT_N = 2 * SLOTS;
    localparam int BIT_W = $clog2(BIT_N) + 1;

    typedef struct packed {
        logic [PH_W-1:0]  ph;
        logic [BIT_W-1:0] bc;
        logic             sclk;
        logic             lrck;
        logic             fall;
    } gen_st_t;

    gen_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.fall = 1'b0;
        if (!en) begin
            st_d = '0;
        end else if (st_q.ph == PH_W'(PH_N - 1)) begin
            st_d.ph   = '0;
            st_d.sclk = 1'b0;
            st_d.fall = 1'b1;
            if (st_q.bc == BIT_W'(BIT_N - 1)) begin
                st_d.bc = '0;
            end else begin
                st_d.bc = st_q.bc + 1'b1;
            end
            st_d.lrck = (st_d.bc >= BIT_W'(SLOTS));
        end else begin
            st_d.ph = st_q.ph + 1'b1;
            if (st_q.ph == PH_W'(HALF_DIV - 1)) begin
                st_d.sclk = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk_o     = st_q.sclk;
    assign lrck_o     = st_q.lrck;
    assign evt_o.fall = st_q.fall;
    assign evt_o.lrck = st_q.lrck;

endmodule

// File: rtl/sap_ext_sync.sv
module sap_ext_sync #(
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              lrck_i,
    output sap_pkg::sap_evt_t evt_o
);
    typedef struct packed {
        logic [STAGES-1:0] sclk_sh;
        logic [STAGES-1:0] lrck_sh;
        logic              sclk_prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_sh   = {st_q.sclk_sh[STAGES-2:0], sclk_i};
        st_d.lrck_sh   = {st_q.lrck_sh[STAGES-2:0], lrck_i};
        st_d.sclk_prev = st_q.sclk_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o.fall = st_q.sclk_prev & ~st_q.sclk_sh[STAGES-1];
    assign evt_o.lrck = st_q.lrck_sh[STAGES-1];

endmodule

// File: rtl/sap_slot_shifter.sv
module sap_slot_shifter #(
    parameter int WORD_W = 24,
    parameter int SLOTS  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sap_pkg::sap_fmt_e fmt_i,
    input  sap_pkg::sap_evt_t evt_i,
    input  logic [WORD_W-1:0] pend_l_i,
    input  logic [WORD_W-1:0] pend_r_i,
    output logic              sdo_o
);
    import sap_pkg::*;

    localparam int SLOT_W = $clog2(SLOTS) + 1;
    localparam int IDX_W  = $clog2(WORD_W);

    typedef struct packed {
        logic              primed;
        logic              lr_prev;
        logic              started;
        logic [SLOT_W-1:0] slot;
        logic [WORD_W-1:0] act_l;
        logic [WORD_W-1:0] act_r;
        logic              sdo;
    } shf_st_t;

    shf_st_t           st_d, st_q;
    logic              lr_edge;
    logic              left_now;
    logic [WORD_W-1:0] word;
    int                pos;
    logic [IDX_W-1:0]  idx;

    always_comb begin
        st_d     = st_q;
        lr_edge  = 1'b0;
        left_now = 1'b0;
        word     = '0;
        pos      = 0;
        idx      = '0;
        if (evt_i.fall) begin
            lr_edge      = st_q.primed && (evt_i.lrck != st_q.lr_prev);
            st_d.primed  = 1'b1;
            st_d.lr_prev = evt_i.lrck;
            if (lr_edge) begin
                st_d.slot = '0;
            end else if (st_q.slot != '1) begin
                st_d.slot = st_q.slot + 1'b1;
            end
            st_d.started = st_q.started | lr_edge;
            left_now     = (fmt_i == FMT_I2S) ? ~evt_i.lrck : evt_i.lrck;
            // whole pair moves at the start of a left channel
            if (lr_edge && left_now) begin
                st_d.act_l = pend_l_i;
                st_d.act_r = pend_r_i;
            end
            word = left_now ? st_d.act_l : st_d.act_r;
            pos  = int'(st_d.slot) - ((fmt_i == FMT_I2S) ? 1 : 0);
            if (st_d.started && pos >= 0 && pos < WORD_W) begin
                idx      = IDX_W'(WORD_W - 1 - pos);
                st_d.sdo = word[idx];
            end else begin
                st_d.sdo = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo_o = st_q.sdo;

endmodule

// File: rtl/sap_tx_port.sv
module sap_tx_port #(
    parameter int WORD_W      = 24,
    parameter int SLOTS       = 32,
    parameter int HALF_DIV    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              ext_sclk_i,
    input  logic              ext_lrck_i,
    input  logic [WORD_W-1:0] sample_l_i,
    input  logic [WORD_W-1:0] sample_r_i,
    input  logic              sample_valid_i,
    input  logic              sdo_strap_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic              sclk_o,
    output logic              lrck_o,
    output logic              clk_drive_o
);
    import sap_pkg::*;

    typedef struct packed {
        logic              strap_done;
        sap_fmt_e          fmt;
        logic [WORD_W-1:0] pend_l;
        logic [WORD_W-1:0] pend_r;
    } top_st_t;

    top_st_t  st_d, st_q;
    sap_evt_t gen_evt;
    sap_evt_t ext_evt;
    sap_evt_t sel_evt;

    always_comb begin
        st_d = st_q;
        if (!st_q.strap_done) begin
            st_d.fmt        = sap_fmt_e'(sdo_strap_i);
            st_d.strap_done = 1'b1;
        end
        if (sample_valid_i) begin
            st_d.pend_l = sample_l_i;
            st_d.pend_r = sample_r_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    sap_bclk_gen #(
        .HALF_DIV (HALF_DIV),
        .SLOTS    (SLOTS)
    ) u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (~slave_mode),
        .sclk_o (sclk_o),
        .lrck_o (lrck_o),
        .evt_o  (gen_evt)
    );

    sap_ext_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_i (ext_sclk_i),
        .lrck_i (ext_lrck_i),
        .evt_o  (ext_evt)
    );

    always_comb begin
        sel_evt      = slave_mode ? ext_evt : gen_evt;
        sel_evt.fall = sel_evt.fall & st_q.strap_done;
    end

    sap_slot_shifter #(
        .WORD_W (WORD_W),
        .SLOTS  (SLOTS)
    ) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .fmt_i    (st_q.fmt),
        .evt_i    (sel_evt),
        .pend_l_i (st_q.pend_l),
        .pend_r_i (st_q.pend_r),
        .sdo_o    (sdo_o)
    );

    // pin released at once on reset, taken over after the strap is read
    assign sdo_oe_o    = st_q.strap_done & rst_n;
    assign clk_drive_o = ~slave_mode;

endmodule

// File: rtl/sap_tx_port_chk.sv
module sap_tx_port_chk (
    input logic clk,
    input logic rst_n,
    input logic slave_mode,
    input logic sdo_o,
    input logic sdo_oe_o,
    input logic sclk_o,
    input logic lrck_o
);
    // R1
    a_r1_pin_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |-> (!sdo_oe_o && !sdo_o));

    // R2
    a_r2_enable_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe_o |=> sdo_oe_o);

    // R3
    a_r3_data_moves_while_bclk_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && !$stable(sdo_o)) |-> !sclk_o);

    // R6
    a_r6_frame_moves_on_bclk_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && !$stable(lrck_o)) |-> $fell(sclk_o));

    // R7
    a_r7_clock_pins_idle_in_slave: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode && $past(slave_mode)) |-> (!sclk_o && !lrck_o));

endmodule

bind sap_tx_port sap_tx_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .slave_mode (slave_mode),
    .sdo_o      (sdo_o),
    .sdo_oe_o   (sdo_oe_o),
    .sclk_o     (sclk_o),
    .lrck_o     (lrck_o)
);

// File: tb/sap_tx_port_tb_top.sv
module sap_tx_port_tb_top;
    localparam int WORD_W   = 24;
    localparam int HALF_DIV = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic slave_mode = 1'b0;
    logic ext_sclk, ext_lrck;
    logic [WORD_W-1:0] sample_l = '0, sample_r = '0;
    logic sample_valid = 1'b0;
    logic sdo_strap = 1'b0;
    logic sdo_o, sdo_oe_o, sclk_o, lrck_o, clk_drive_o;

    int tests = 0;
    int fails = 0;
    bit slave_run = 1'b0;
    bit hold_lrck = 1'b0;
    int sdiv, sbit;

    // {slave, framing(1=I2S), left, right}
    localparam logic [49:0] VEC [6] = '{
        {1'b0, 1'b0, 24'h800001, 24'h7FFFFE},
        {1'b0, 1'b1, 24'hA5C3F0, 24'h123456},
        {1'b1, 1'b0, 24'hFFFFFF, 24'h000000},
        {1'b1, 1'b1, 24'h000001, 24'h800000},
        {1'b0, 1'b0, 24'h5A5A5A, 24'hC0FFEE},
        {1'b1, 1'b1, 24'h7FFFFF, 24'hFFFFFF}
    };

    always #10 clk = ~clk;

    sap_tx_port dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .slave_mode     (slave_mode),
        .ext_sclk_i     (ext_sclk),
        .ext_lrck_i     (ext_lrck),
        .sample_l_i     (sample_l),
        .sample_r_i     (sample_r),
        .sample_valid_i (sample_valid),
        .sdo_strap_i    (sdo_strap),
        .sdo_o          (sdo_o),
        .sdo_oe_o       (sdo_oe_o),
        .sclk_o         (sclk_o),
        .lrck_o         (lrck_o),
        .clk_drive_o    (clk_drive_o)
    );

    // remote clock source for slave mode: bit clock half period 6 clocks
    initial begin
        ext_sclk = 1'b0; ext_lrck = 1'b0; sdiv = 0; sbit = 0;
        forever begin
            @(negedge clk);
            if (!slave_run) begin
                ext_sclk = 1'b0; ext_lrck = 1'b0; sdiv = 0; sbit = 0;
            end else begin
                sdiv++;
                if (sdiv == 6) begin
                    sdiv = 0;
                    if (ext_sclk) begin
                        ext_sclk = 1'b0;
                        sbit = (sbit + 1) % 64;
                        if (!hold_lrck && (sbit % 32) == 0) ext_lrck = ~ext_lrck;
                    end else begin
                        ext_sclk = 1'b1;
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic get_bit(output logic lr, output logic d);
        if (slave_mode) @(posedge ext_sclk); else @(posedge sclk_o);
        #1;
        lr = slave_mode ? ext_lrck : lrck_o;
        d  = sdo_o;
    endtask

    task automatic apply_pair(input logic [WORD_W-1:0] l, input logic [WORD_W-1:0] r);
        @(negedge clk);
        sample_l = l; sample_r = r; sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    // receiver model: decode one frame from the first left start after `skip` left starts
    task automatic capture(input logic fmt, input int skip, input bit inject,
                           input logic [WORD_W-1:0] inj_l, input logic [WORD_W-1:0] inj_r,
                           output logic [WORD_W-1:0] l, output logic [WORD_W-1:0] r,
                           output int zero_bad, output int side_bad, output bit found);
        logic lr, d, prev, left_lvl;
        int seen, tries, k, pos;
        left_lvl = fmt ? 1'b0 : 1'b1;
        seen = 0; tries = 0; found = 1'b0;
        l = '0; r = '0; zero_bad = 0; side_bad = 0;
        get_bit(prev, d);
        while (!found && tries < 400) begin
            get_bit(lr, d);
            tries++;
            if (lr == left_lvl && prev != left_lvl) begin
                if (seen == skip) found = 1'b1; else seen++;
            end
            prev = lr;
        end
        if (found) begin
            for (int s = 0; s < 64; s++) begin
                if (s > 0) get_bit(lr, d);
                k = s % 32;
                if (lr != ((s < 32) ? left_lvl : ~left_lvl)) side_bad++;
                pos = k - (fmt ? 1 : 0);
                if (pos >= 0 && pos < WORD_W) begin
                    if (s < 32) l[WORD_W-1-pos] = d; else r[WORD_W-1-pos] = d;
                end else if (d) begin
                    zero_bad++;
                end
                if (inject && s == 10) apply_pair(inj_l, inj_r);
            end
        end
    endtask

    task automatic do_reset(input logic slv, input logic strap);
        slave_run = 1'b0;
        @(negedge clk);
        rst_n = 1'b0; slave_mode = slv; sdo_strap = strap;
        repeat (4) @(negedge clk);
        chk(!sdo_oe_o, "R1 oe in reset", 32'(sdo_oe_o), 0);
        chk(!sdo_o, "R1 data in reset", 32'(sdo_o), 0);
        rst_n = 1'b1;
        #1;
        chk(!sdo_oe_o, "R2 oe before strap edge", 32'(sdo_oe_o), 0);
        @(negedge clk);
        chk(sdo_oe_o, "R2 oe after strap edge", 32'(sdo_oe_o), 1);
        slave_run = slv;
    endtask

    task automatic frame_check(input logic fmt, input logic slv, input string tag,
                               input logic [WORD_W-1:0] el, input logic [WORD_W-1:0] er,
                               input int skip);
        logic [WORD_W-1:0] gl, gr;
        int zb, sb;
        bit f;
        capture(fmt, skip, 1'b0, '0, '0, gl, gr, zb, sb, f);
        chk(f, {tag, " frame start found"}, 32'(f), 1);
        chk(gl == el, {tag, " left word"}, 32'(gl), 32'(el));
        chk(gr == er, {tag, " right word"}, 32'(gr), 32'(er));
        chk(zb == 0, {tag, " unused slots zero"}, 32'(zb), 0);
        chk(sb == 0, slv ? "R7 half length follows remote clock" : "R6 32 slots per half",
            32'(sb), 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog (all R) actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [WORD_W-1:0] gl, gr;
        int zb, sb, ones;
        bit f;
        logic a, b, lr, d;
        time t0, t1;
        #2 rst_n = 1'b0;

        // vector table: both framings (R4, R5) in both clock modes (R6, R7)
        for (int v = 0; v < 6; v++) begin
            logic slv, fmt;
            logic [WORD_W-1:0] vl, vr;
            {slv, fmt, vl, vr} = VEC[v];
            do_reset(slv, fmt);
            chk(clk_drive_o == ~slv, slv ? "R7 clock pins released" : "R6 clock pins driven",
                32'(clk_drive_o), 32'(~slv));
            apply_pair(vl, vr);
            frame_check(fmt, slv, fmt ? "R5" : "R4", vl, vr, 1);
            if (slv) chk(!sclk_o && !lrck_o, "R7 generated clocks idle",
                         32'({sclk_o, lrck_o}), 0);
        end

        // R2: strap changed after startup is ignored
        do_reset(1'b0, 1'b0);
        sdo_strap = 1'b1;
        apply_pair(24'h800001, 24'h400003);
        frame_check(1'b0, 1'b0, "R2 strap held LJ", 24'h800001, 24'h400003, 1);

        // R8: pair written mid-frame only shows in later frames
        apply_pair(24'h111111, 24'h222222);
        capture(1'b0, 1, 1'b1, 24'hABCDEF, 24'h654321, gl, gr, zb, sb, f);
        chk(gl == 24'h111111, "R8 left not split", 32'(gl), 32'h111111);
        chk(gr == 24'h222222, "R8 right not split", 32'(gr), 32'h222222);
        capture(1'b0, 0, 1'b0, '0, '0, gl, gr, zb, sb, f);
        chk(gl == 24'hABCDEF, "R8 new left next frame", 32'(gl), 32'hABCDEF);
        chk(gr == 24'h654321, "R8 new right next frame", 32'(gr), 32'h654321);
        apply_pair(24'h0F0F0F, 24'hF0F0F0);
        apply_pair(24'h3C3C3C, 24'hC3C3C3);
        capture(1'b0, 1, 1'b0, '0, '0, gl, gr, zb, sb, f);
        chk(gl == 24'h3C3C3C && gr == 24'hC3C3C3, "R8 last write wins",
            32'(gl), 32'h3C3C3C);

        // R3: data stable while the bit clock is high
        ones = 0;
        for (int i = 0; i < 20; i++) begin
            @(posedge sclk_o); #1 a = sdo_o;
            @(negedge sclk_o); #1 b = sdo_o;
            if (a != b) ones++;
        end
        chk(ones == 0, "R3 data changes only after fall", 32'(ones), 0);

        // R6: bit clock period
        @(posedge sclk_o); t0 = $time;
        @(posedge sclk_o); t1 = $time;
        chk((t1 - t0) == 2 * HALF_DIV * 20, "R6 bit clock period", 32'(t1 - t0),
            32'(2 * HALF_DIV * 20));

        // R9: no frame-clock edge yet, line stays at zero
        hold_lrck = 1'b1;
        do_reset(1'b1, 1'b0);
        apply_pair(24'hFFFFFF, 24'hFFFFFF);
        ones = 0;
        for (int i = 0; i < 40; i++) begin
            get_bit(lr, d);
            if (d) ones++;
        end
        chk(ones == 0, "R9 quiet before framing", 32'(ones), 0);
        hold_lrck = 1'b0;
        slave_run = 1'b0;

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule